// File: doc/BRIEF.md
# SPI Status Flag Clearing Logic

This block is the register-side flag logic of an SPI peripheral. It holds three status flags: transmit buffer empty, transfer complete and mode fault. It clears each flag only after a two-step bus sequence. First, a status read must return the flag as 1, which arms it. Then a specific access must follow: a low-byte data read, a low-byte data write, or a control write. The serial shift engine stays outside the block. It reports its events as single-cycle pulses and takes its transmit word from the `tx_data` output.

The block supports 8-bit and 16-bit transfer widths. Both widths use a low and a high data byte lane, selected on the CPU bus with byte enables. In 16-bit mode the order of byte-lane accesses matters. Reading or writing only the high byte never clears a flag. The low-byte access, alone or as part of a word access, completes the sequence. Each flag has its own interrupt enable. The interrupt line is the registered OR of the enabled flags.

Register map: address 0 is the control register, address 1 is the status register and address 2 is the data register. Control bits are: [0] transmit-empty interrupt enable, [1] transfer-complete interrupt enable, [2] mode-fault interrupt enable, [3] master, [4] mode-fault detect enable, [5] 16-bit width. Status bits are: [7] transfer complete, [5] transmit empty, [4] mode fault.

Top module: `spi_flag_ctl`

## Requirements
- R1: After reset the status register reads 0x0020 (only transmit empty set), `tx_data` is 0 and `irq` is 0.
- R2: A data or control access that is not preceded by a status read showing the flag set leaves that flag set.
- R3: In 8-bit mode, a low-byte data read (be=01) after an arming status read clears transfer complete and returns the received byte in rdata[7:0], with rdata[15:8] zero.
- R4: In 16-bit mode, high-byte-only reads (be=10) return the received high byte in rdata[15:8] any number of times and leave transfer complete set. A following low-byte read, or a word read (be=11), clears it.
- R5: A low-byte data write after an arming status read clears transmit empty.
- R6: In 16-bit mode, a high-byte write leaves transmit empty set and the following low-byte write clears it. A word write also clears it. `tx_data` then shows both written bytes.
- R7: A data write made while transmit empty is 0 leaves `tx_data` unchanged.
- R8: Mode fault sets on a falling edge of `ss_n` only when master and mode-fault detect are both enabled.
- R9: Mode fault clears on a control write only after an arming status read.
- R10: When a hardware set event and a clearing access fall in the same cycle, the flag stays set and its arming is lost. A later access clears the flag only after a new status read.
- R11: `irq` equals the OR of each flag ANDed with its enable, one clock later.
- R12: `tx_load` sets transmit empty. `xfer_done` sets transfer complete and captures `rx_data` (the low byte only in 8-bit mode).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 2 | Register select: 0 control, 1 status, 2 data |
| rd_en | input | 1 | Read strobe, one cycle per access |
| wr_en | input | 1 | Write strobe, one cycle per access |
| be | input | 2 | Byte enables: bit 0 low byte, bit 1 high byte |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, combinational while rd_en is high |
| ss_n | input | 1 | Slave-select input, already synchronised |
| xfer_done | input | 1 | Shift engine finished a transfer (pulse) |
| rx_data | input | 16 | Received word, valid with xfer_done |
| tx_load | input | 1 | Shift engine took the transmit word (pulse) |
| tx_data | output | 16 | Transmit word for the shift engine |
| irq | output | 1 | Registered interrupt request |

## Verification
The embedded properties assume that `rd_en` and `wr_en` are never high together and that each strobe marks exactly one access per cycle. They also assume that `xfer_done` and `tx_load` are single-cycle pulses and that `ss_n` is already synchronous to `clk`. The stimulus drives every input at the falling edge and holds it for one full cycle. It never raises both strobes and returns every pulse to 0 after one cycle. Collisions between set events and clearing accesses are created on purpose, so the set-wins rule is exercised.

// File: rtl/spi_flag_pkg.sv
package spi_flag_pkg;

    localparam int BYTE_W  = 8;
    localparam int NBYTE   = 2;
    localparam int DATA_W  = BYTE_W * NBYTE;
    localparam int ADDR_W  = 2;
    localparam int NFLAG   = 3;

    // flag indices, shared by set/clear vectors and interrupt enables
    localparam int IDX_TXE  = 0;
    localparam int IDX_XFR  = 1;
    localparam int IDX_MODF = 2;

    // status register bit positions
    localparam int STAT_XFR_BIT  = 7;
    localparam int STAT_TXE_BIT  = 5;
    localparam int STAT_MODF_BIT = 4;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_STAT = 2'd1,
        REG_DATA = 2'd2
    } reg_sel_e;

    typedef struct packed {
        logic [1:0]       rsvd;
        logic             wide;
        logic             fault_det;
        logic             master;
        logic [NFLAG-1:0] irq_en;
    } ctrl_t;

    typedef struct packed {
        logic stat_rd;
        logic ctrl_wr;
        logic lo_rd;
        logic lo_wr;
        logic hi_wr;
    } bus_acc_t;

    function automatic logic [DATA_W-1:0] pack_status(input logic [NFLAG-1:0] f);
        logic [DATA_W-1:0] s;
        s = '0;
        s[STAT_XFR_BIT]  = f[IDX_XFR];
        s[STAT_TXE_BIT]  = f[IDX_TXE];
        s[STAT_MODF_BIT] = f[IDX_MODF];
        return s;
    endfunction

endpackage

// File: rtl/spi_flag_dec.sv
module spi_flag_dec
    import spi_flag_pkg::*;
(
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [NBYTE-1:0]  be,
    output bus_acc_t          acc
);

    logic sel_stat, sel_ctrl, sel_data;

    always_comb begin
        sel_stat    = (addr == REG_STAT);
        sel_ctrl    = (addr == REG_CTRL);
        sel_data    = (addr == REG_DATA);
        acc.stat_rd = rd_en & sel_stat;
        acc.ctrl_wr = wr_en & sel_ctrl;
        acc.lo_rd   = rd_en & sel_data & be[0];
        acc.lo_wr   = wr_en & sel_data & be[0];
        acc.hi_wr   = wr_en & sel_data & be[1];
    end

endmodule

// File: rtl/spi_flag_cell.sv
module spi_flag_cell #(
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst,
    input  logic set_evt,
    input  logic clr_acc,
    input  logic stat_rd,
    output logic flag_o
);

    logic flag_q;
    logic arm_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            flag_q <= RST_VAL;
            arm_q  <= 1'b0;
        end else if (set_evt) begin
            flag_q <= 1'b1;
            arm_q  <= 1'b0;
        end else if (clr_acc && arm_q) begin
            flag_q <= 1'b0;
            arm_q  <= 1'b0;
        end else if (stat_rd && flag_q) begin
            arm_q  <= 1'b1;
        end
    end

    assign flag_o = flag_q;

    // R2
    unarmed_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (flag_q && !arm_q) |=> flag_q);

    // R10
    set_wins_chk: assert property (@(posedge clk) disable iff (rst)
        set_evt |=> (flag_q && !arm_q));

    // R4
    idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
        (!set_evt && !clr_acc) |=> $stable(flag_q));

    // R2
    arm_needs_flag_chk: assert property (@(posedge clk) disable iff (rst)
        arm_q |-> flag_q);

endmodule

// File: rtl/spi_flag_data.sv
module spi_flag_data
    import spi_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wide,
    input  logic              txe,
    input  logic              lo_wr,
    input  logic              hi_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              xfer_done,
    input  logic [DATA_W-1:0] rx_in,
    input  logic [NBYTE-1:0]  be,
    output logic [DATA_W-1:0] tx_out,
    output logic [DATA_W-1:0] rx_rd
);

    logic [DATA_W-1:0] tx_q;
    logic [DATA_W-1:0] rx_q;
    logic [NBYTE-1:0]  lane_wr;
    logic [NBYTE-1:0]  lane_on;

    assign lane_on = {wide, 1'b1};
    assign lane_wr = {hi_wr, lo_wr} & lane_on & {NBYTE{txe}};

    for (genvar b = 0; b < NBYTE; b++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) begin
                tx_q[b*BYTE_W +: BYTE_W] <= '0;
                rx_q[b*BYTE_W +: BYTE_W] <= '0;
            end else begin
                if (lane_wr[b])
                    tx_q[b*BYTE_W +: BYTE_W] <= wdata[b*BYTE_W +: BYTE_W];
                if (xfer_done)
                    rx_q[b*BYTE_W +: BYTE_W] <= lane_on[b] ? rx_in[b*BYTE_W +: BYTE_W] : '0;
            end
        end
        assign tx_out[b*BYTE_W +: BYTE_W] = lane_on[b] ? tx_q[b*BYTE_W +: BYTE_W] : '0;
        assign rx_rd[b*BYTE_W +: BYTE_W]  = (lane_on[b] && be[b]) ? rx_q[b*BYTE_W +: BYTE_W] : '0;
    end

    // R7
    gated_write_chk: assert property (@(posedge clk) disable iff (rst)
        ((lo_wr || hi_wr) && !txe) |=> $stable(tx_q));

    // R12
    rx_capture_chk: assert property (@(posedge clk) disable iff (rst)
        xfer_done |=> (rx_q[BYTE_W-1:0] == $past(rx_in[BYTE_W-1:0])));

endmodule

// File: rtl/spi_flag_ctl.sv
module spi_flag_ctl
    import spi_flag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] addr,
    input  logic              rd_en,
    input  logic              wr_en,
    input  logic [NBYTE-1:0]  be,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ss_n,
    input  logic              xfer_done,
    input  logic [DATA_W-1:0] rx_data,
    input  logic              tx_load,
    output logic [DATA_W-1:0] tx_data,
    output logic              irq
);

    bus_acc_t          acc;
    ctrl_t             ctrl_q;
    logic              ss_q;
    logic              ss_fall;
    logic [NFLAG-1:0]  set_v;
    logic [NFLAG-1:0]  clr_v;
    logic [NFLAG-1:0]  flags;
    logic [DATA_W-1:0] rx_rd;
    logic              irq_q;

    spi_flag_dec u_dec (
        .addr  (addr),
        .rd_en (rd_en),
        .wr_en (wr_en),
        .be    (be),
        .acc   (acc)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q <= '0;
            ss_q   <= 1'b1;
            irq_q  <= 1'b0;
        end else begin
            if (acc.ctrl_wr)
                ctrl_q <= ctrl_t'(wdata[$bits(ctrl_t)-1:0]);
            ss_q  <= ss_n;
            irq_q <= |(flags & ctrl_q.irq_en);
        end
    end

    assign ss_fall = ss_q & ~ss_n;

    always_comb begin
        set_v           = '0;
        clr_v           = '0;
        set_v[IDX_TXE]  = tx_load;
        set_v[IDX_XFR]  = xfer_done;
        set_v[IDX_MODF] = ss_fall & ctrl_q.master & ctrl_q.fault_det;
        clr_v[IDX_TXE]  = acc.lo_wr;
        clr_v[IDX_XFR]  = acc.lo_rd;
        clr_v[IDX_MODF] = acc.ctrl_wr;
    end

    for (genvar i = 0; i < NFLAG; i++) begin : g_flag
        spi_flag_cell #(
            .RST_VAL ((i == IDX_TXE) ? 1'b1 : 1'b0)
        ) u_cell (
            .clk     (clk),
            .rst     (rst),
            .set_evt (set_v[i]),
            .clr_acc (clr_v[i]),
            .stat_rd (acc.stat_rd),
            .flag_o  (flags[i])
        );
    end

    spi_flag_data u_data (
        .clk       (clk),
        .rst       (rst),
        .wide      (ctrl_q.wide),
        .txe       (flags[IDX_TXE]),
        .lo_wr     (acc.lo_wr),
        .hi_wr     (acc.hi_wr),
        .wdata     (wdata),
        .xfer_done (xfer_done),
        .rx_in     (rx_data),
        .be        (be),
        .tx_out    (tx_data),
        .rx_rd     (rx_rd)
    );

    always_comb begin
        rdata = '0;
        if (rd_en) begin
            case (addr)
                REG_CTRL: rdata = DATA_W'(ctrl_q);
                REG_STAT: rdata = pack_status(flags);
                REG_DATA: rdata = rx_rd;
                default:  rdata = '0;
            endcase
        end
    end

    assign irq = irq_q;

    // R11
    irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !(|(flags & ctrl_q.irq_en)) |=> !irq);

    // R11
    irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
        (|(flags & ctrl_q.irq_en)) |=> irq);

    // R8
    no_fault_when_off_chk: assert property (@(posedge clk) disable iff (rst)
        (!(ctrl_q.master && ctrl_q.fault_det) && !flags[IDX_MODF]) |=> !flags[IDX_MODF]);

endmodule

// File: tb/sim_spi_flag_ctl.sv
`timescale 1ns/1ps
module sim_spi_flag_ctl;
    import spi_flag_pkg::*;

    localparam logic [2:0] OP_RSTAT = 3'd0;
    localparam logic [2:0] OP_RDATA = 3'd1;
    localparam logic [2:0] OP_WDATA = 3'd2;
    localparam logic [2:0] OP_WCTRL = 3'd3;
    localparam logic [2:0] OP_XFER  = 3'd4;
    localparam logic [2:0] OP_LOAD  = 3'd5;
    localparam logic [2:0] OP_CHKTX = 3'd6;

    typedef struct packed {
        logic [2:0]  op;
        logic [1:0]  be;
        logic [15:0] d;
        logic        chk;
        logic [15:0] exp;
        logic [7:0]  req;
    } vec_t;

    localparam int NVEC = 36;
    localparam vec_t TBL [NVEC] = '{
        '{OP_WCTRL, 2'b11, 16'h0018, 1'b0, 16'h0000, 8'd9},
        '{OP_RSTAT, 2'b11, 16'h0000, 1'b1, 16'h0020, 8'd1},   // R1
        '{OP_WDATA, 2'b01, 16'h00A5, 1'b0, 16'h0000, 8'd5},
        '{OP_RSTAT, 2'b11, 16'h0000, 1'b1, 16'h0000, 8'd5},   // R5
        '{OP_WDATA, 2'b01, 16'h005A, 1'b0, 16'h0000, 8'd7},
        '{OP_CHKTX, 2'b00, 16'h0000, 1'b1, 16'h00A5, 8'd7},   // R7
        '{OP_LOAD,  2'b00, 16'h0000, 1'b0, 16'h0000, 8'd12},
        '{OP_XFER,  2'b00, 16'h1234, 1'b0, 16'h0000, 8'd12},
        '{OP_RDATA, 2'b01, 16'h0000, 1'b1, 16'h0034, 8'd3},   // R3
        '{OP_RSTAT, 2'b11, 16'h0000, 1'b1, 16'h00A0, 8'd2},   // R2 R12
        '{OP_RDATA, 2'b01, 16'h0000, 1'b1, 16'h0034, 8'd3},
        '{OP_RSTAT, 2'b11, 16'h0000, 1'b1, 16'h0020, 8'd3},
        '{OP_WCTRL, 2'b11, 16'h0038, 1'b0, 16'h0000, 8'd4},
        '{OP_XFER,  2'b00, 16'hBEEF, 1'b0, 16'h0000, 8'd12},
        '{OP_RSTAT, 2'b11, 16'h0000, 1'b1, 16'h00A0, 8'd12},
        '{OP_RDATA, 2'b10, 16'h0000, 1'b1, 16'hBE00, 8'd4},   // R4
        '{OP_RDATA, 2'b10, 16'h0000, 1'b1, 16'hBE00, 8'd4},
        '{OP_RSTAT, 2'b11, 16'h0000, 1'b1, 16'h00A0, 8'd4},
        '{OP_RDATA, 2'b01, 16'h0000, 1'b1, 16'h00EF, 8'd4},
        '{OP_RSTAT, 2'b11, 16'h0000, 1'b1, 16'h0020, 8'd4},
        '{OP_XFER,  2'b00, 16'hCAFE, 1'b0, 16'h0000, 8'd12},
        '{OP_RSTAT, 2'b11, 16'h0000, 1'b1, 16'h00A0, 8'd4},
        '{OP_RDATA, 2'b11, 16'h0000, 1'b1, 16'hCAFE, 8'd4},
        '{OP_RSTAT, 2'b11, 16'h0000, 1'b1, 16'h0020, 8'd4},
        '{OP_WDATA, 2'b10, 16'h1100, 1'b0, 16'h0000, 8'd6},
        '{OP_RSTAT, 2'b11, 16'h0000, 1'b1, 16'h0020, 8'd6},   // R6
        '{OP_WDATA, 2'b01, 16'h0022, 1'b0, 16'h0000, 8'd6},
        '{OP_RSTAT, 2'b11, 16'h0000, 1'b1, 16'h0000, 8'd6},
        '{OP_CHKTX, 2'b00, 16'h0000, 1'b1, 16'h1122, 8'd6},
        '{OP_LOAD,  2'b00, 16'h0000, 1'b0, 16'h0000, 8'd12},
        '{OP_RSTAT, 2'b11, 16'h0000, 1'b1, 16'h0020, 8'd12},
        '{OP_WDATA, 2'b11, 16'h3344, 1'b0, 16'h0000, 8'd6},
        '{OP_RSTAT, 2'b11, 16'h0000, 1'b1, 16'h0000, 8'd6},
        '{OP_CHKTX, 2'b00, 16'h0000, 1'b1, 16'h3344, 8'd6},
        '{OP_LOAD,  2'b00, 16'h0000, 1'b0, 16'h0000, 8'd12},
        '{OP_RSTAT, 2'b11, 16'h0000, 1'b1, 16'h0020, 8'd12}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  addr = '0;
    logic        rd_en = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  be = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        ss_n = 1'b1;
    logic        xfer_done = 1'b0;
    logic [15:0] rx_data = '0;
    logic        tx_load = 1'b0;
    logic [15:0] tx_data;
    logic        irq;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    spi_flag_ctl u0 (
        .clk(clk), .rst(rst), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
        .be(be), .wdata(wdata), .rdata(rdata), .ss_n(ss_n),
        .xfer_done(xfer_done), .rx_data(rx_data), .tx_load(tx_load),
        .tx_data(tx_data), .irq(irq)
    );

    task automatic check(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_op(input logic [2:0] op, input logic [1:0] b, input logic [15:0] d,
                          input bit evt_x, output logic [15:0] rd);
        @(negedge clk);
        be = b;
        wdata = d;
        rx_data = d;
        case (op)
            OP_RSTAT: begin addr = 2'd1; rd_en = 1'b1; end
            OP_RDATA: begin addr = 2'd2; rd_en = 1'b1; end
            OP_WDATA: begin addr = 2'd2; wr_en = 1'b1; end
            OP_WCTRL: begin addr = 2'd0; wr_en = 1'b1; end
            OP_XFER:  xfer_done = 1'b1;
            OP_LOAD:  tx_load = 1'b1;
            default:  ;
        endcase
        if (evt_x) xfer_done = 1'b1;
        #1 rd = rdata;
        @(posedge clk);
        #1;
        rd_en = 1'b0; wr_en = 1'b0; xfer_done = 1'b0; tx_load = 1'b0;
        if (op == OP_CHKTX) rd = tx_data;
    endtask

    task automatic expect_stat(input logic [15:0] exp, input string req);
        logic [15:0] r;
        bus_op(OP_RSTAT, 2'b11, 16'h0, 1'b0, r);
        check(r == exp, req, r, exp);
    endtask

    task automatic ss_fall_pulse();
        @(negedge clk); ss_n = 1'b0;
        @(negedge clk); ss_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] r;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset outputs
        check(tx_data == 16'h0, "R1 tx_data", tx_data, 16'h0);
        check(irq == 1'b0, "R1 irq", {15'h0, irq}, 16'h0);

        for (int i = 0; i < NVEC; i++) begin
            bus_op(TBL[i].op, TBL[i].be, TBL[i].d, 1'b0, r);
            if (TBL[i].chk)
                check(r == TBL[i].exp, $sformatf("R%0d row %0d", TBL[i].req, i), r, TBL[i].exp);
        end

        // R8: master off, then detect off, then both on
        bus_op(OP_WCTRL, 2'b11, 16'h0020, 1'b0, r);
        ss_fall_pulse();
        expect_stat(16'h0020, "R8 master off");
        bus_op(OP_WCTRL, 2'b11, 16'h0028, 1'b0, r);
        ss_fall_pulse();
        expect_stat(16'h0020, "R8 detect off");
        bus_op(OP_WCTRL, 2'b11, 16'h0038, 1'b0, r);
        ss_fall_pulse();
        // R9: unarmed control write leaves fault set
        bus_op(OP_WCTRL, 2'b11, 16'h0038, 1'b0, r);
        expect_stat(16'h0030, "R9 unarmed ctrl write / R8 set");
        bus_op(OP_WCTRL, 2'b11, 16'h0038, 1'b0, r);
        expect_stat(16'h0020, "R9 armed ctrl write");

        // R10: collision of set and clearing read
        bus_op(OP_XFER, 2'b00, 16'h0011, 1'b0, r);
        expect_stat(16'h00A0, "R10 armed");
        bus_op(OP_RDATA, 2'b01, 16'h0011, 1'b1, r);
        bus_op(OP_RDATA, 2'b01, 16'h0000, 1'b0, r);
        expect_stat(16'h00A0, "R10 set wins, arm lost");
        bus_op(OP_RDATA, 2'b01, 16'h0000, 1'b0, r);
        expect_stat(16'h0020, "R10 clears after rearm");

        // R11: interrupt latency
        bus_op(OP_WCTRL, 2'b11, 16'h003A, 1'b0, r);
        @(negedge clk); xfer_done = 1'b1; rx_data = 16'h0;
        @(posedge clk); #1 xfer_done = 1'b0;
        check(irq == 1'b0, "R11 not yet", {15'h0, irq}, 16'h0);
        @(posedge clk); #1;
        check(irq == 1'b1, "R11 raised", {15'h0, irq}, 16'h1);
        bus_op(OP_RSTAT, 2'b11, 16'h0, 1'b0, r);
        bus_op(OP_RDATA, 2'b01, 16'h0, 1'b0, r);
        check(irq == 1'b1, "R11 still high", {15'h0, irq}, 16'h1);
        @(posedge clk); #1;
        check(irq == 1'b0, "R11 dropped", {15'h0, irq}, 16'h0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule